// File: doc/BRIEF.md
# Synchronizable Clock-Start Oscillator with Period Acceptance Window

This block is the timing source for a two-channel switching controller. It runs a phase counter in system clock cycles and produces two narrow start pulses per period, half a period apart. The main channel's pulse comes at phase zero. The auxiliary channel's pulse comes at mid-period. A square-wave sync output rises together with the auxiliary pulse, so other controllers can follow this one.

An external sync input can take over the timing. The block measures the time between successive rising edges of that input. It sorts each interval into one of three classes against limits derived from the programmed period: accepted, rejected, or in a hysteresis band between the two. The lock state changes only after two consecutive edges agree. While locked, every edge that is not rejected restarts the phase at zero and sets the tracked period to the measured interval. When lock is lost, the counter simply keeps running at the programmed period. It is never restarted, so no truncated period is produced.

Top module: `osc_sync_tracker`

## Requirements
- R1: While reset is asserted, all four outputs are 0.
- R2: While unlocked, a main pulse starts every P system cycles, where P is `period_i` (P must be at least twice the pulse width). Each main pulse lasts exactly PULSE_CYC cycles (default 20, i.e. 100 ns at 200 MHz).
- R3: Each auxiliary pulse starts floor(L/2) cycles after the main pulse, where L is the active period, and lasts PULSE_CYC cycles.
- R4: `sync_o` rises in the same cycle as the auxiliary pulse and stays high for L - floor(L/2) cycles of every period.
- R5: The interval M between two sync rising edges is classified as follows, using limits floor(P*k/16):
  - accepted when floor(15P/16) <= M <= floor(20P/16);
  - rejected when M < floor(13P/16) or M > floor(24P/16);
  - in the band otherwise.
- R6: The first rising edge after reset only starts a measurement. Two consecutive accepted intervals set `locked_o`. From then on, each main pulse rises 3 cycles after the sync input rises (two synchronizer stages plus one register), and the main period equals the measured interval.
- R7: While unlocked, band or rejected intervals never set the lock, and the oscillator keeps its free-running period P.
- R8: While locked, band intervals keep the lock and are tracked, exactly as accepted ones are.
- R9: While locked, one rejected interval is ignored: it causes no re-phasing and does not drop the lock. A second consecutive rejected interval clears `locked_o`.
- R10: While locked, if no sync edge arrives within 2P cycles of the last one, `locked_o` clears. The counter then continues without a restart, so every main-pulse interval lies between P and the last tracked period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | PW (12) | Programmed period in system cycles |
| sync_i | input | 1 | External sync input, asynchronous |
| main_pulse_o | output | 1 | Main channel start pulse |
| aux_pulse_o | output | 1 | Auxiliary channel start pulse |
| sync_o | output | 1 | 50% sync output, rising with the auxiliary pulse |
| locked_o | output | 1 | High while following the external sync |

## Verification
In steady lock, a re-phase request from a sync edge and the counter's own wrap fall in the same cycle. That happens because the tracked period equals the measured interval. The bench drives edges at exactly the tracked period and at the window limits. It judges the result by requiring a main-pulse interval of exactly the sync interval, with the rise exactly three cycles after the input edge; a double pulse or an off-by-one interval would break both. The timeout and a late edge can also coincide. Holding the input low across the 2P boundary, and bounding every interval afterwards, shows that dropping the lock never restarts the counter.

// File: rtl/osc_sync_pkg.sv
`timescale 1ns/1ps
package osc_sync_pkg;
   typedef enum logic [1:0] {
      WIN_IN   = 2'd0,
      WIN_BAND = 2'd1,
      WIN_OUT  = 2'd2
   } win_cls_e;
endpackage

// File: rtl/osc_sync_edge.sv
`timescale 1ns/1ps
// Synchronizer chain plus one history stage; flags a rising edge.
module osc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES:0] chain_q;

   genvar g;
   generate
      for (g = 0; g <= STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/osc_period_meter.sv
`timescale 1ns/1ps
// Measures cycles between sync edges and classifies each interval.
module osc_period_meter
   import osc_sync_pkg::*;
#(
   parameter int PW        = 12,
   parameter int MW        = PW + 1,
   parameter int ACC_LO_16 = 15,
   parameter int ACC_HI_16 = 20,
   parameter int REJ_LO_16 = 13,
   parameter int REJ_HI_16 = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] period_i,
   input  logic          rise_i,
   output logic          edge_v_o,
   output logic [MW-1:0] meas_o,
   output win_cls_e      cls_o,
   output logic          stale_o
);
   localparam int XW = PW + 6;
   localparam logic [MW-1:0] MEAS_SAT = {MW{1'b1}};

   logic [MW-1:0] meas_q;
   logic          seen_q;
   logic [XW-1:0] p_x, m_x, acc_lo, acc_hi, rej_lo, rej_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_q <= '0;
         seen_q <= 1'b0;
      end else if (rise_i) begin
         meas_q <= MW'(1);
         seen_q <= 1'b1;
      end else if (meas_q != MEAS_SAT) begin
         meas_q <= meas_q + 1'b1;
      end
   end

   assign p_x    = XW'(period_i);
   assign m_x    = XW'(meas_q);
   assign acc_lo = (p_x * XW'(ACC_LO_16)) >> 4;
   assign acc_hi = (p_x * XW'(ACC_HI_16)) >> 4;
   assign rej_lo = (p_x * XW'(REJ_LO_16)) >> 4;
   assign rej_hi = (p_x * XW'(REJ_HI_16)) >> 4;

   always_comb begin
      if ((m_x < rej_lo) || (m_x > rej_hi))       cls_o = WIN_OUT;
      else if ((m_x >= acc_lo) && (m_x <= acc_hi)) cls_o = WIN_IN;
      else                                         cls_o = WIN_BAND;
   end

   assign edge_v_o = rise_i & seen_q;
   assign meas_o   = meas_q;
   assign stale_o  = m_x >= (p_x << 1);
endmodule

// File: rtl/osc_lock_ctrl.sv
`timescale 1ns/1ps
// Two-edge confirmation of lock state, tracked period, re-phase request.
module osc_lock_ctrl
   import osc_sync_pkg::*;
#(
   parameter int MW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          edge_v_i,
   input  win_cls_e      cls_i,
   input  logic [MW-1:0] meas_i,
   input  logic          stale_i,
   output logic          locked_o,
   output logic [MW-1:0] trk_o,
   output logic          rephase_o
);
   logic          locked_q, locked_d;
   logic          streak_q, streak_d;
   logic [MW-1:0] trk_q, trk_d;

   always_comb begin
      locked_d  = locked_q;
      streak_d  = streak_q;
      trk_d     = trk_q;
      rephase_o = 1'b0;
      if (edge_v_i) begin
         if (!locked_q) begin
            if (cls_i == WIN_IN) begin
               if (streak_q) begin
                  locked_d  = 1'b1;
                  streak_d  = 1'b0;
                  trk_d     = meas_i;
                  rephase_o = 1'b1;
               end else begin
                  streak_d = 1'b1;
               end
            end else begin
               streak_d = 1'b0;
            end
         end else begin
            if (cls_i == WIN_OUT) begin
               if (streak_q) begin
                  locked_d = 1'b0;
                  streak_d = 1'b0;
               end else begin
                  streak_d = 1'b1;
               end
            end else begin
               streak_d  = 1'b0;
               trk_d     = meas_i;
               rephase_o = 1'b1;
            end
         end
      end else if (locked_q && stale_i) begin
         locked_d = 1'b0;
         streak_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         streak_q <= 1'b0;
         trk_q    <= '0;
      end else begin
         locked_q <= locked_d;
         streak_q <= streak_d;
         trk_q    <= trk_d;
      end
   end

   assign locked_o = locked_q;
   assign trk_o    = trk_q;
endmodule

// File: rtl/osc_phase_gen.sv
`timescale 1ns/1ps
// Phase counter and registered pulse / square-wave outputs.
module osc_phase_gen #(
   parameter int PW        = 12,
   parameter int MW        = PW + 1,
   parameter int PULSE_CYC = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] period_i,
   input  logic          locked_i,
   input  logic [MW-1:0] trk_i,
   input  logic          rephase_i,
   output logic          main_o,
   output logic          aux_o,
   output logic          sync_o
);
   localparam logic [MW-1:0] PULSE_W = MW'(PULSE_CYC);

   logic [MW-1:0] cnt_q, cnt_d, lim, half;
   logic          started_q;

   assign lim  = locked_i ? trk_i : MW'(period_i);
   assign half = lim >> 1;

   always_comb begin
      if (!started_q || rephase_i || (cnt_q >= lim - 1'b1)) cnt_d = '0;
      else                                                   cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started_q <= 1'b0;
         cnt_q     <= '0;
         main_o    <= 1'b0;
         aux_o     <= 1'b0;
         sync_o    <= 1'b0;
      end else begin
         started_q <= 1'b1;
         cnt_q     <= cnt_d;
         main_o    <= cnt_d < PULSE_W;
         aux_o     <= (cnt_d >= half) && (cnt_d < half + PULSE_W);
         sync_o    <= cnt_d >= half;
      end
   end
endmodule

// File: rtl/osc_sync_tracker.sv
`timescale 1ns/1ps
// Synchronizable two-phase clock-start oscillator with acceptance window.
module osc_sync_tracker
   import osc_sync_pkg::*;
#(
   parameter int PW          = 12,
   parameter int PULSE_CYC   = 20,
   parameter int SYNC_STAGES = 2,
   parameter int ACC_LO_16   = 15,
   parameter int ACC_HI_16   = 20,
   parameter int REJ_LO_16   = 13,
   parameter int REJ_HI_16   = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] period_i,
   input  logic          sync_i,
   output logic          main_pulse_o,
   output logic          aux_pulse_o,
   output logic          sync_o,
   output logic          locked_o
);
   localparam int MW = PW + 1;

   generate
      if (!(REJ_LO_16 < ACC_LO_16 && ACC_LO_16 <= 16 && ACC_HI_16 >= 16 &&
            ACC_HI_16 < REJ_HI_16 && REJ_HI_16 <= 32)) begin : g_bad_window
         $error("window limits must nest: reject-low < accept-low <= 16 <= accept-high < reject-high <= 32");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("at least two synchronizer stages are required");
      end
      if (PULSE_CYC < 1 || PULSE_CYC >= (1 << (PW - 1))) begin : g_bad_pulse
         $error("pulse width must be positive and below half the largest period");
      end
   endgenerate

   logic          rise, edge_v, stale, rephase, locked;
   logic [MW-1:0] meas, trk;
   win_cls_e      cls;

   osc_sync_edge #(.STAGES(SYNC_STAGES)) i_edge (
      .clk(clk), .rst_n(rst_n), .async_i(sync_i), .rise_o(rise)
   );

   osc_period_meter #(
      .PW(PW), .MW(MW),
      .ACC_LO_16(ACC_LO_16), .ACC_HI_16(ACC_HI_16),
      .REJ_LO_16(REJ_LO_16), .REJ_HI_16(REJ_HI_16)
   ) i_meter (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .rise_i(rise),
      .edge_v_o(edge_v), .meas_o(meas), .cls_o(cls), .stale_o(stale)
   );

   osc_lock_ctrl #(.MW(MW)) i_lock (
      .clk(clk), .rst_n(rst_n), .edge_v_i(edge_v), .cls_i(cls),
      .meas_i(meas), .stale_i(stale), .locked_o(locked),
      .trk_o(trk), .rephase_o(rephase)
   );

   osc_phase_gen #(.PW(PW), .MW(MW), .PULSE_CYC(PULSE_CYC)) i_phase (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .locked_i(locked),
      .trk_i(trk), .rephase_i(rephase), .main_o(main_pulse_o),
      .aux_o(aux_pulse_o), .sync_o(sync_o)
   );

   assign locked_o = locked;
endmodule

// File: rtl/osc_sync_tracker_chk.sv
`timescale 1ns/1ps
// Port-level checker; tracks cycles since the last sync input rise.
module osc_sync_tracker_chk #(
   parameter int PW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic [PW-1:0] period_i,
   input logic          sync_i,
   input logic          main_pulse_o,
   input logic          aux_pulse_o,
   input logic          sync_o,
   input logic          locked_o
);
   localparam int GW = PW + 3;

   logic          sync_d;
   logic [GW-1:0] gap;
   logic [GW-1:0] two_p;

   assign two_p = {2'b00, period_i, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_d <= 1'b0;
         gap    <= {GW{1'b1}};
      end else begin
         sync_d <= sync_i;
         if (sync_i && !sync_d)   gap <= '0;
         else if (gap != {GW{1'b1}}) gap <= gap + 1'b1;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!main_pulse_o && !aux_pulse_o && !sync_o && !locked_o));

   assert_aux_in_sync_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      aux_pulse_o |-> sync_o);

   assert_lock_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> (gap == GW'(2) && main_pulse_o));

   assert_unlock_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_o) |-> (gap == GW'(2) || gap > two_p));

   assert_timeout_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |-> (gap <= two_p + GW'(2)));
endmodule

bind osc_sync_tracker osc_sync_tracker_chk #(.PW(PW)) i_chk (
   .clk(clk), .rst_n(rst_n), .period_i(period_i), .sync_i(sync_i),
   .main_pulse_o(main_pulse_o), .aux_pulse_o(aux_pulse_o),
   .sync_o(sync_o), .locked_o(locked_o)
);

// File: tb/test_osc_sync_tracker.sv
`timescale 1ns/1ps
module test_osc_sync_tracker;
   localparam int PW = 12;
   localparam int PULSE = 20;
   localparam int VEC_N = 10;
   localparam int VP [VEC_N] = '{64, 64, 64, 64, 64, 64, 64, 40, 40, 64};
   localparam int VQ [VEC_N] = '{64, 60, 80, 52, 51, 96, 97, 44, 36, 72};
   localparam int VL [VEC_N] = '{ 1,  1,  1,  0,  0,  0,  0,  1,  0,  1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PW-1:0] period_i = 12'd64;
   logic          sync_i = 1'b0;
   logic          main_pulse_o, aux_pulse_o, sync_o, locked_o;

   int checks = 0, fails = 0, cyc = 0;
   int last_main = -1, last_aux = -1, last_sync = -1;
   int ivl_last = 0, ivl_min = 0, ivl_max = 0, rise_c = -1;
   int main_hi = 0, aux_hi = 0, sync_hi = 0;
   logic main_p = 1'b0, aux_p = 1'b0, sync_p = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   osc_sync_tracker #(.PW(PW), .PULSE_CYC(PULSE)) i_osc_sync_tracker (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .sync_i(sync_i),
      .main_pulse_o(main_pulse_o), .aux_pulse_o(aux_pulse_o),
      .sync_o(sync_o), .locked_o(locked_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_stats();
      ivl_min = 1 << 30; ivl_max = 0;
      main_hi = 0; aux_hi = 0; sync_hi = 0;
   endtask

   task automatic tick(input logic s, input int c);
      @(negedge clk);
      if (main_pulse_o && !main_p) begin
         if (last_main >= 0) begin
            ivl_last = cyc - last_main;
            if (ivl_last < ivl_min) ivl_min = ivl_last;
            if (ivl_last > ivl_max) ivl_max = ivl_last;
         end
         last_main = cyc;
         rise_c = c;
      end
      if (aux_pulse_o && !aux_p) last_aux = cyc;
      if (sync_o && !sync_p)     last_sync = cyc;
      if (main_pulse_o) main_hi++;
      if (aux_pulse_o)  aux_hi++;
      if (sync_o)       sync_hi++;
      main_p = main_pulse_o; aux_p = aux_pulse_o; sync_p = sync_o;
      sync_i = s;
      cyc++;
   endtask

   task automatic do_reset(input int p);
      rst_n = 1'b0;
      period_i = PW'(p);
      for (int i = 0; i < 4; i++) tick(1'b0, -1);
      last_main = -1; last_aux = -1; last_sync = -1; rise_c = -1;
      main_p = 1'b0; aux_p = 1'b0; sync_p = 1'b0;
      clear_stats();
      rst_n = 1'b1;
   endtask

   task automatic sync_edges(input int q, input int n);
      for (int k = 0; k < n; k++)
         for (int c = 0; c < q; c++) tick(c < q / 2, c);
   endtask

   initial begin
      // R1: outputs quiet during reset
      for (int i = 0; i < 3; i++) tick(1'b0, -1);
      check("R1", "main in reset", int'(main_pulse_o), 0);
      check("R1", "aux in reset", int'(aux_pulse_o), 0);
      check("R1", "sync_o in reset", int'(sync_o), 0);
      check("R1", "locked in reset", int'(locked_o), 0);

      // Vector table: R5 window boundaries, R6 lock/tracking, R7 no lock
      for (int v = 0; v < VEC_N; v++) begin
         do_reset(VP[v]);
         sync_edges(VQ[v], 8);
         check(VL[v] != 0 ? "R6" : "R7", $sformatf("R5 lock for P=%0d Q=%0d", VP[v], VQ[v]),
               int'(locked_o), VL[v]);
         check(VL[v] != 0 ? "R6" : "R7", $sformatf("main period P=%0d Q=%0d", VP[v], VQ[v]),
               ivl_last, VL[v] != 0 ? VQ[v] : VP[v]);
         if (VL[v] != 0) check("R6", "main rise offset after sync edge", rise_c, 3);
      end

      // R2 R3 R4: free run with no sync, four whole periods
      do_reset(64);
      for (int i = 0; i < 40; i++) tick(1'b0, -1);
      clear_stats();
      for (int i = 0; i < 256; i++) tick(1'b0, -1);
      check("R2", "main high cycles in 4 periods", main_hi, 4 * PULSE);
      check("R2", "min main interval", ivl_min, 64);
      check("R2", "max main interval", ivl_max, 64);
      check("R3", "aux high cycles in 4 periods", aux_hi, 4 * PULSE);
      check("R3", "aux offset from main", (((last_aux - last_main) % 64) + 64) % 64, 32);
      check("R4", "sync_o high cycles in 4 periods", sync_hi, 128);
      check("R4", "sync_o rise with aux", last_sync, last_aux);

      // R7 hysteresis from unlocked: alternating accepted and band intervals
      do_reset(64);
      sync_edges(64, 1);
      for (int i = 0; i < 4; i++) begin
         sync_edges(90, 1);
         sync_edges(64, 1);
      end
      check("R7", "alternating in/band never locks", int'(locked_o), 0);
      sync_edges(64, 3);
      check("R6", "two consecutive accepted intervals lock", int'(locked_o), 1);

      // R8: band intervals while locked are tracked
      do_reset(64);
      sync_edges(64, 6);
      sync_edges(90, 5);
      check("R8", "band keeps lock", int'(locked_o), 1);
      check("R8", "band interval tracked", ivl_last, 90);
      check("R8", "band edge re-phases", rise_c, 3);

      // R9: one rejected interval ignored, second drops lock
      do_reset(64);
      sync_edges(64, 6);
      check("R9", "locked before rejected edges", int'(locked_o), 1);
      sync_edges(40, 1);
      sync_edges(40, 1);
      check("R9", "single rejected interval keeps lock", int'(locked_o), 1);
      check("R9", "rejected edge not re-phased", rise_c, 27);
      sync_edges(40, 1);
      check("R9", "second rejected interval unlocks", int'(locked_o), 0);

      // R10: timeout after 2P without edges, no counter restart
      do_reset(64);
      sync_edges(72, 6);
      check("R10", "locked at 72", int'(locked_o), 1);
      clear_stats();
      for (int i = 0; i < 40; i++) tick(1'b0, -1);
      check("R10", "still locked before 2P", int'(locked_o), 1);
      for (int i = 0; i < 30; i++) tick(1'b0, -1);
      check("R10", "unlocked after 2P", int'(locked_o), 0);
      for (int i = 0; i < 300; i++) tick(1'b0, -1);
      check("R10", "no interval below P", int'(ivl_min >= 64), 1);
      check("R10", "no interval above tracked", int'(ivl_max <= 72), 1);
      check("R10", "free-run resumes at P", ivl_last, 64);

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule